// File: doc/BRIEF.md
# Flash Word Program Command Interface

This block fronts a small flash-like word array with a command decoder and a status register. A host writes and reads through a plain write-enable/read-enable port with an address and a data word. To program a word, the host first writes a setup command byte and then writes the target address together with the new data. The block captures that pair on the clock edge, checks the program-voltage flag and the protection of the target block, and then runs a timed program-and-verify step on its own.

While the operation runs, the ready flag in the status register is low and a busy output is high. Once the setup command has been accepted, reads return the status byte rather than array contents. This continues until the host writes the read-array command. Programming can only clear bits, so the stored word becomes the old word ANDed with the new one. Verify reports an error when a requested 1 cannot be reached. A clear-status command resets the sticky error flags.

The array is split into equal blocks by the upper address bits, and each block has one lock input. A write-protect input held high overrides the locks.

Top module: `flash_prog_cmd`

## Requirements
- R1: After reset, array reads return all ones in every word, reads are in array mode, the status byte is 80h and `stsBusy` is 0.
- R2: A write whose low byte is 40h or 10h arms a program and switches reads to status. The next write supplies the target address and data.
- R3: After an accepted data write, status bit 7 reads 0 and `stsBusy` is 1 for exactly BUSY_CYC cycles. After that, bit 7 reads 1 and `stsBusy` is 0.
- R4: When the operation completes, the target word holds its previous value ANDed with the written data.
- R5: If the written data has a 1 where the previous word has a 0, status bit 4 is set on completion.
- R6: If `vppOk` is 0 at the data write, status bits 3 and 4 are set, no busy period occurs and the array is unchanged. This check takes priority over the lock check.
- R7: If the target block's lock bit is 1 and `wpHigh` is 0 at the data write, status bits 1 and 4 are set and the array is unchanged. With `wpHigh` at 1, a locked block is programmed normally.
- R8: Writes that arrive while busy are ignored, including mode commands.
- R9: A write of 50h when idle clears status bits 1, 3, 4 and 5, and leaves the read mode unchanged.
- R10: A write of FFh when idle returns reads to array data. Otherwise, status mode persists across any number of reads.
- R11: Other command bytes written when idle have no effect on the read mode or the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| rdEn | input | 1 | Read enable; `rdData` is 0 when low |
| addr | input | AW | Word address; the top BLK_BITS bits select the block |
| wrData | input | DW | Write data; the low byte carries command codes |
| rdData | output | DW | Status byte (zero-extended) or array word |
| vppOk | input | 1 | Program voltage valid |
| wpHigh | input | 1 | Write-protect override; 1 allows programming of locked blocks |
| lockBits | input | 2**BLK_BITS | One lock bit per block |
| stsBusy | output | 1 | High while a program operation runs |

## Verification
The bench targets the exact busy length. A counter that is off by one would show up as bit 7 or `stsBusy` changing one cycle early or late against the per-clock model. It programs a word with data that tries to raise zero bits. A design that stored the new data directly would read back the wrong word, and one that checked the wrong polarity would miss bit 4.

It applies low voltage and a locked block at the same time to confirm that only bits 3 and 4 appear. It also confirms that a locked block is still programmed when the override is high. It sends read-array and setup bytes during a busy period, where a design that decoded them would leave status mode or re-arm. It sends an unknown byte in status mode, where a design that fell back to array reads would be caught.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_SETUP      = 8'h40;
  localparam logic [7:0] CMD_SETUP_ALT  = 8'h10;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BUSY
  } ctrlState_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic setVppErr;
    logic setLockErr;
    logic clrErr;
    logic busy;
    logic showStatus;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  cmdByte,
  input  logic        vppOk,
  input  logic        lockHit,
  input  logic        wpHigh,
  output ctrlStrobe_t strobe
);

  localparam int CW = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);

  ctrlState_t    state;
  logic [CW-1:0] cnt;
  logic          showStatus;
  logic          acceptWr;

  assign acceptWr = wrEn && (state != ST_BUSY);

  always_comb begin
    strobe = '0;
    strobe.busy = (state == ST_BUSY);
    strobe.showStatus = showStatus;
    if (acceptWr && state == ST_ARMED) begin
      if (!vppOk)                  strobe.setVppErr  = 1'b1;
      else if (lockHit && !wpHigh) strobe.setLockErr = 1'b1;
      else                         strobe.capture    = 1'b1;
    end
    if (acceptWr && state == ST_IDLE && cmdByte == CMD_CLR_STATUS)
      strobe.clrErr = 1'b1;
    if (state == ST_BUSY && cnt == '0)
      strobe.commit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      showStatus <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            if (cmdByte == CMD_SETUP || cmdByte == CMD_SETUP_ALT) begin
              state      <= ST_ARMED;
              showStatus <= 1'b1;
            end else if (cmdByte == CMD_READ_ARRAY) begin
              showStatus <= 1'b0;
            end
          end
        end
        ST_ARMED: begin
          if (wrEn) begin
            showStatus <= 1'b1;
            if (strobe.capture) begin
              state <= ST_BUSY;
              cnt   <= CW'(BUSY_CYC - 1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_BUSY: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the busy counter steps down by one each cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && cnt != '0) |=> (state == ST_BUSY && cnt == $past(cnt) - CW'(1)));

  // R3: the last busy cycle hands back to idle
  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && cnt == '0) |=> (state == ST_IDLE));

  // R8: a write while busy leaves the read mode alone
  a_r8_busy_ignores_wr: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && wrEn) |=> $stable(showStatus));

  // R2: either setup code arms the sequence and selects status reads
  a_r2_arm: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wrEn && (cmdByte == CMD_SETUP || cmdByte == CMD_SETUP_ALT))
    |=> (state == ST_ARMED && showStatus));

  // R10: the read-array command leaves status mode
  a_r10_array_mode: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wrEn && cmdByte == CMD_READ_ARRAY) |=> !showStatus);

  // R6: the outcomes of a data write are mutually exclusive
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.setVppErr, strobe.setLockErr}));

endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_cmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] capAddr;
  logic [DW-1:0] capData;
  logic          errLock, errVpp, errProg;
  logic [DW-1:0] oldWord;
  logic          verifyFail;
  logic [7:0]    statusByte;

  assign oldWord    = mem[capAddr];
  assign verifyFail = |(capData & ~oldWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      capAddr <= '0;
      capData <= '0;
      errLock <= 1'b0;
      errVpp  <= 1'b0;
      errProg <= 1'b0;
    end else begin
      if (strobe.capture) begin
        capAddr <= addr;
        capData <= wrData;
      end
      if (strobe.commit) begin
        mem[capAddr] <= oldWord & capData;
        if (verifyFail) errProg <= 1'b1;
      end
      if (strobe.setVppErr) begin
        errVpp  <= 1'b1;
        errProg <= 1'b1;
      end
      if (strobe.setLockErr) begin
        errLock <= 1'b1;
        errProg <= 1'b1;
      end
      if (strobe.clrErr) begin
        errLock <= 1'b0;
        errVpp  <= 1'b0;
        errProg <= 1'b0;
      end
    end
  end

  assign statusByte = {!strobe.busy, 2'b00, errProg, errVpp, 1'b0, errLock, 1'b0};

  always_comb begin
    if (!rdEn)                  rdData = '0;
    else if (strobe.showStatus) rdData = DW'(statusByte);
    else                        rdData = mem[addr];
  end

  // R4: the committed word holds only bits set in both old and new
  a_r4_and_merge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ((mem[$past(capAddr)] & ~$past(capData)) == '0));

  // R5: a requested 1 over a stored 0 raises the program error
  a_r5_verify: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && verifyFail) |=> errProg);

  // R6: low program voltage raises bits 3 and 4
  a_r6_vpp_err: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setVppErr |=> (errVpp && errProg));

  // R7: a protected block raises bits 1 and 4
  a_r7_lock_err: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setLockErr |=> (errLock && errProg));

  // R9: clear-status empties every error flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrErr |=> (!errLock && !errVpp && !errProg));

endmodule

// File: rtl/flash_prog_cmd.sv
module flash_prog_cmd
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int BLK_BITS = 2,
  parameter int BUSY_CYC = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wrData,
  output logic [DW-1:0]            rdData,
  input  logic                     vppOk,
  input  logic                     wpHigh,
  input  logic [(1<<BLK_BITS)-1:0] lockBits,
  output logic                     stsBusy
);

  ctrlStrobe_t strobe;
  logic        lockHit;

  assign lockHit = lockBits[addr[AW-1 -: BLK_BITS]];
  assign stsBusy = strobe.busy;

  flash_prog_ctrl #(.BUSY_CYC(BUSY_CYC)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .cmdByte (wrData[7:0]),
    .vppOk   (vppOk),
    .lockHit (lockHit),
    .wpHigh  (wpHigh),
    .strobe  (strobe)
  );

  flash_prog_dp #(.AW(AW), .DW(DW)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .wrData (wrData),
    .rdEn   (rdEn),
    .rdData (rdData)
  );

endmodule

// File: tb/test_flash_prog_cmd.sv
`timescale 1ns/1ps
module test_flash_prog_cmd;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int BB = 2;
  localparam int B  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic vppOk = 1'b1, wpHigh = 1'b0;
  logic [(1<<BB)-1:0] lockBits = '0;
  logic stsBusy;

  always #4 clk = ~clk;

  flash_prog_cmd #(.AW(AW), .DW(DW), .BLK_BITS(BB), .BUSY_CYC(B)) i_flash_prog_cmd (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .vppOk(vppOk), .wpHigh(wpHigh),
    .lockBits(lockBits), .stsBusy(stsBusy)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference state
  logic [DW-1:0] m [1<<AW];
  bit armed = 0, statusMode = 0, errL = 0, errV = 0, errP = 0;
  int busyLeft = 0;
  int capA = 0;
  logic [DW-1:0] capD = '0;

  function automatic logic [DW-1:0] expRead(int a);
    logic [7:0] s;
    s = {busyLeft == 0, 2'b00, errP, errV, 1'b0, errL, 1'b0};
    if (statusMode) return DW'(s);
    return m[a];
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(bit we, int a, logic [DW-1:0] d);
    if (busyLeft > 0) begin
      if (busyLeft == 1) begin
        if ((capD & ~m[capA]) != 0) errP = 1;
        m[capA] = m[capA] & capD;
      end
      busyLeft--;
    end else if (we) begin
      if (armed) begin
        armed = 0;
        statusMode = 1;
        if (!vppOk) begin errV = 1; errP = 1; end
        else if (lockBits[a >> (AW-BB)] && !wpHigh) begin errL = 1; errP = 1; end
        else begin busyLeft = B; capA = a; capD = d; end
      end else begin
        case (d[7:0])
          8'h40, 8'h10: begin armed = 1; statusMode = 1; end
          8'h50: begin errL = 0; errV = 0; errP = 0; end
          8'hFF: statusMode = 0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic tick(bit we, bit re, int a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    wrEn = we; rdEn = re; addr = AW'(a); wrData = d;
    #1;
    check({tag, " busy"}, DW'(stsBusy), DW'(busyLeft > 0));
    if (re) check(tag, rdData, expRead(a));
    @(posedge clk);
    modelStep(we, a, d);
  endtask

  task automatic wr(int a, logic [DW-1:0] d, string tag); tick(1, 0, a, d, tag); endtask
  task automatic rd(int a, string tag); tick(0, 1, a, '0, tag); endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) m[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    rd(0, "R1"); rd(5, "R1"); rd(63, "R1");
    // R2 R3 R4 program with standard setup
    wr(0, 16'h0040, "R2");
    rd(3, "R2");
    wr(3, 16'h12F0, "R2");
    for (int i = 0; i < B + 2; i++) rd(3, "R3");
    rd(9, "R10");
    wr(0, 16'h00FF, "R10");
    rd(3, "R4");
    // R5 alternate setup, raise zero bits; R8 commands during busy
    wr(0, 16'h0010, "R2");
    wr(3, 16'h0F0F, "R5");
    rd(3, "R3");
    wr(0, 16'h00FF, "R8");
    rd(3, "R8");
    wr(0, 16'h0040, "R8");
    for (int i = 0; i < B; i++) rd(3, "R3");
    rd(3, "R5");
    // R11 unknown command in status mode
    wr(0, 16'h0020, "R11");
    rd(3, "R11");
    // R9 clear status keeps status mode
    wr(0, 16'h0050, "R9");
    rd(3, "R9");
    wr(0, 16'h00FF, "R10");
    rd(3, "R4");
    // R6 low program voltage
    vppOk = 1'b0;
    wr(0, 16'h0040, "R6");
    wr(10, 16'h0000, "R6");
    rd(10, "R6"); rd(10, "R6");
    wr(0, 16'h00FF, "R6");
    rd(10, "R6");
    vppOk = 1'b1;
    wr(0, 16'h0050, "R9");
    // R7 locked block with protect low
    lockBits = 4'b0010;
    wr(0, 16'h0040, "R7");
    wr(20, 16'h00FF, "R7");
    rd(20, "R7");
    wr(0, 16'h00FF, "R7");
    rd(20, "R7");
    wr(0, 16'h0050, "R9");
    // R7 override allows programming
    wpHigh = 1'b1;
    wr(0, 16'h0040, "R7");
    wr(20, 16'h00FF, "R7");
    for (int i = 0; i < B + 1; i++) rd(20, "R3");
    wr(0, 16'h00FF, "R7");
    rd(20, "R7");
    // R6 priority over lock
    wpHigh = 1'b0; vppOk = 1'b0;
    wr(0, 16'h0050, "R9");
    wr(0, 16'h0040, "R6");
    wr(21, 16'h0000, "R6");
    rd(21, "R6");
    wr(0, 16'h00FF, "R6");
    rd(21, "R6");
    vppOk = 1'b1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (R3): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule